// File: doc/BRIEF.md
# Reset cause capture register

This block remembers which reset sources have fired since software last looked, and presents them as one 8-bit read-only status register on a simple synchronous read bus. Each source reaches the block as a single-cycle event pulse. The sources are power-on, the external reset pin, a watchdog timeout, an illegal opcode, an opcode fetch from an illegal address, monitor-mode entry and low-voltage inhibit.

A power-on event wipes everything else, so the register then holds only the power-on flag. Every other event adds its own flag to what is already held. Software reads the register once, and that read clears it. The block decides for itself whether monitor-mode entry occurred. It watches a vector-check strobe, which carries the two reset-vector bytes and the IRQ pin level, and applies the check only once after each power-on.

Top module: `rst_cause_capture`

## Requirements
- R1: When `rst_ni` is released, which models power-up, the register holds 0x80.
- R2: A power-on event loads the register with bit 7 set and with every other bit cleared, except the bits of events in that same cycle. Power-on together with an external-pin event gives 0xC0.
- R3: Each non-power-on event sets only its own bit and keeps all other bits. Bit 6 is the external pin, bit 5 the watchdog, bit 4 the illegal opcode, bit 3 the illegal-address fetch, bit 2 monitor entry and bit 1 low voltage.
- R4: A read (`rd_en_i` high, `addr_i` = 0xFE01) returns the register value in the same cycle, as it was before any clear.
- R5: A read clears the whole register at the next clock edge.
- R6: An event that arrives in the same cycle as a read survives the clear. Only its bit is set afterwards.
- R7: The illegal-address event sets bit 3 only when `fetch_i` marks the access as an opcode fetch.
- R8: Bit 2 is set by a `vec_chk_i` pulse in which both vector bytes are 0xFF and `irq_high_i` is 1. This applies only to the first such pulse after power-on. Any `vec_chk_i` pulse disarms the check until the next power-on.
- R9: A read at any other address returns 0x00 and leaves the register unchanged. The bus has no write path.
- R10: Bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| pwr_on_evt_i | input | 1 | Power-on event pulse |
| pin_evt_i | input | 1 | External reset pin event pulse |
| wdog_evt_i | input | 1 | Watchdog timeout event pulse |
| bad_op_evt_i | input | 1 | Illegal opcode event pulse |
| bad_addr_evt_i | input | 1 | Illegal address access pulse |
| fetch_i | input | 1 | Qualifies `bad_addr_evt_i` as an opcode fetch |
| low_volt_evt_i | input | 1 | Low-voltage inhibit event pulse |
| vec_chk_i | input | 1 | Strobe: reset-vector bytes and IRQ level are valid |
| vec_hi_i | input | 8 | Vector byte at 0xFFFE |
| vec_lo_i | input | 8 | Vector byte at 0xFFFF |
| irq_high_i | input | 1 | IRQ pin sits at the supply level |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 16 | Bus address |
| rdata_o | output | 8 | Read data |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. Every effect of an event or a clear shows up only after one clock edge, so it appears on the next read. The bench drives each stimulus on the falling edge and compares `rdata_o` one nanosecond later against a behavioural model. That model advances only after the following rising edge, so every comparison sees exactly one update per edge. Collision and same-cycle cases are checked with explicit constants on the read that follows.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int FLAG_W    = 8;
  localparam int BIT_PWR   = 7;
  localparam int BIT_PIN   = 6;
  localparam int BIT_WDOG  = 5;
  localparam int BIT_OP    = 4;
  localparam int BIT_FETCH = 3;
  localparam int BIT_MON   = 2;
  localparam int BIT_LOWV  = 1;
  typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/rst_cause_mon_detect.sv
module rst_cause_mon_detect #(
  parameter int          VEC_W = 8,
  parameter logic [VEC_W-1:0] BLANK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_on_i,
  input  logic             vec_chk_i,
  input  logic [VEC_W-1:0] vec_hi_i,
  input  logic [VEC_W-1:0] vec_lo_i,
  input  logic             irq_high_i,
  output logic             mon_evt_o
);
  logic armed_q;

  // one check per power-on; power-on re-arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b1;
    else if (pwr_on_i)  armed_q <= 1'b1;
    else if (vec_chk_i) armed_q <= 1'b0;
  end

  assign mon_evt_o = armed_q && vec_chk_i && irq_high_i &&
                     (vec_hi_i == BLANK) && (vec_lo_i == BLANK);
endmodule

// File: rtl/rst_cause_event_map.sv
module rst_cause_event_map
  import rst_cause_pkg::*;
(
  input  logic   pwr_on_i,
  input  logic   pin_i,
  input  logic   wdog_i,
  input  logic   bad_op_i,
  input  logic   bad_addr_i,
  input  logic   fetch_i,
  input  logic   mon_i,
  input  logic   low_volt_i,
  output flags_t set_o
);
  always_comb begin
    set_o            = '0;
    set_o[BIT_PWR]   = pwr_on_i;
    set_o[BIT_PIN]   = pin_i;
    set_o[BIT_WDOG]  = wdog_i;
    set_o[BIT_OP]    = bad_op_i;
    set_o[BIT_FETCH] = bad_addr_i & fetch_i;
    set_o[BIT_MON]   = mon_i;
    set_o[BIT_LOWV]  = low_volt_i;
  end
endmodule

// File: rtl/rst_cause_flag_store.sv
module rst_cause_flag_store
  import rst_cause_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pwr_on_i,
  input  logic   clr_i,
  input  flags_t set_i,
  output flags_t flags_o
);
  flags_t flags_q, flags_d;
  flags_t rst_val;

  always_comb begin
    rst_val          = '0;
    rst_val[BIT_PWR] = 1'b1;
  end

  // power-on wipes; otherwise clear-on-read, then events win
  always_comb begin
    if (pwr_on_i)   flags_d = set_i;
    else if (clr_i) flags_d = set_i;
    else            flags_d = flags_q | set_i;
    flags_d[0] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= rst_val;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  assert_pwr_wipe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_on_i |=> flags_q[BIT_PWR] && ((flags_q & ~$past(set_i)) == '0));
  assert_keep_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_on_i && !clr_i) |=> (($past(flags_q) & ~flags_q) == '0));
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> flags_q == '0);
  assert_event_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !pwr_on_i) |=> flags_q == $past(set_i));
  assert_bit0_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[0] == 1'b0);
endmodule

// File: rtl/rst_cause_capture.sv
module rst_cause_capture
  import rst_cause_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE01,
  parameter int               VEC_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_evt_i,
  input  logic              pin_evt_i,
  input  logic              wdog_evt_i,
  input  logic              bad_op_evt_i,
  input  logic              bad_addr_evt_i,
  input  logic              fetch_i,
  input  logic              low_volt_evt_i,
  input  logic              vec_chk_i,
  input  logic [VEC_W-1:0]  vec_hi_i,
  input  logic [VEC_W-1:0]  vec_lo_i,
  input  logic              irq_high_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [FLAG_W-1:0] rdata_o
);
  logic   mon_evt;
  logic   rd_hit;
  flags_t set_vec;
  flags_t flags;

  rst_cause_mon_detect #(.VEC_W(VEC_W), .BLANK({VEC_W{1'b1}})) i_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_on_i   (pwr_on_evt_i),
    .vec_chk_i  (vec_chk_i),
    .vec_hi_i   (vec_hi_i),
    .vec_lo_i   (vec_lo_i),
    .irq_high_i (irq_high_i),
    .mon_evt_o  (mon_evt)
  );

  rst_cause_event_map i_map (
    .pwr_on_i   (pwr_on_evt_i),
    .pin_i      (pin_evt_i),
    .wdog_i     (wdog_evt_i),
    .bad_op_i   (bad_op_evt_i),
    .bad_addr_i (bad_addr_evt_i),
    .fetch_i    (fetch_i),
    .mon_i      (mon_evt),
    .low_volt_i (low_volt_evt_i),
    .set_o      (set_vec)
  );

  assign rd_hit = rd_en_i && (addr_i == REG_ADDR);

  rst_cause_flag_store i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_on_i (pwr_on_evt_i),
    .clr_i    (rd_hit),
    .set_i    (set_vec),
    .flags_o  (flags)
  );

  assign rdata_o = rd_hit ? {flags[FLAG_W-1:1], 1'b0} : '0;

  assert_fetch_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_addr_evt_i && !fetch_i) |-> !set_vec[BIT_FETCH]);
  assert_miss_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_hit && !pwr_on_evt_i && set_vec == '0) |=> $stable(flags));
  assert_mon_needs_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_high_i |-> !set_vec[BIT_MON]);
endmodule

// File: tb/test_rst_cause_capture.sv
module test_rst_cause_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr = 0, pin = 0, wdog = 0, bop = 0, badr = 0, fetch = 0, lowv = 0;
  logic        vchk = 0, irq = 0, rd = 0;
  logic [7:0]  vhi = 0, vlo = 0;
  logic [15:0] addr = 0;
  logic [7:0]  rdata;

  int checks = 0, fails = 0;
  logic [7:0] m_flags = 8'h80;
  bit         m_armed = 1'b1;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  rst_cause_capture i_rst_cause_capture (
    .clk_i(clk), .rst_ni(rst_n), .pwr_on_evt_i(pwr), .pin_evt_i(pin),
    .wdog_evt_i(wdog), .bad_op_evt_i(bop), .bad_addr_evt_i(badr), .fetch_i(fetch),
    .low_volt_evt_i(lowv), .vec_chk_i(vchk), .vec_hi_i(vhi), .vec_lo_i(vlo),
    .irq_high_i(irq), .rd_en_i(rd), .addr_i(addr), .rdata_o(rdata)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%02h expected %02h", tag, act, exp);
    end
  endtask

  // one cycle: compare against model, then advance model on the edge
  task automatic tick(input string tag);
    logic [7:0] set_b;
    bit hit;
    #1;
    hit = rd && (addr == 16'hFE01);
    chk(rdata, hit ? m_flags : 8'h00, tag);
    @(posedge clk);
    set_b = 8'h00;
    if (pwr)  set_b |= 8'h80;
    if (pin)  set_b |= 8'h40;
    if (wdog) set_b |= 8'h20;
    if (bop)  set_b |= 8'h10;
    if (badr && fetch) set_b |= 8'h08;
    if (vchk && m_armed && irq && vhi == 8'hFF && vlo == 8'hFF) set_b |= 8'h04;
    if (lowv) set_b |= 8'h02;
    if (pwr)       m_flags = set_b;
    else if (hit)  m_flags = set_b;
    else           m_flags = m_flags | set_b;
    if (pwr) m_armed = 1'b1; else if (vchk) m_armed = 1'b0;
    @(negedge clk);
    {pwr, pin, wdog, bop, badr, fetch, lowv, vchk, irq, rd} = '0;
    vhi = 0; vlo = 0; addr = 0;
  endtask

  task automatic rd_expect(input logic [7:0] exp, input string tag);
    rd = 1; addr = 16'hFE01;
    #1;
    chk(rdata, exp, tag);
    chk({7'b0, rdata[0]}, 8'h00, "R10 bit0");
    tick(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_expect(8'h80, "R1 reset value");
    rd_expect(8'h00, "R5 cleared by read");
    pin = 1;  tick("R3"); rd_expect(8'h40, "R3 pin bit6");
    wdog = 1; tick("R3"); rd_expect(8'h20, "R3 wdog bit5");
    bop = 1;  tick("R3"); rd_expect(8'h10, "R3 opcode bit4");
    badr = 1; fetch = 1; tick("R7"); rd_expect(8'h08, "R7 fetch bit3");
    lowv = 1; tick("R3"); rd_expect(8'h02, "R3 lowv bit1");
    vchk = 1; irq = 1; vhi = 8'hFF; vlo = 8'hFF; tick("R8");
    rd_expect(8'h04, "R8 monitor entry");
    vchk = 1; irq = 1; vhi = 8'hFF; vlo = 8'hFF; tick("R8");
    rd_expect(8'h00, "R8 disarmed");
    pwr = 1; tick("R2"); rd_expect(8'h80, "R2 power-on");
    vchk = 1; irq = 1; vhi = 8'hFF; vlo = 8'hFE; tick("R8");
    rd_expect(8'h00, "R8 byte not blank");
    pwr = 1; tick("R2"); rd_expect(8'h80, "R2 power-on");
    vchk = 1; irq = 0; vhi = 8'hFF; vlo = 8'hFF; tick("R8");
    rd_expect(8'h00, "R8 irq low");
    pwr = 1; tick("R2"); lowv = 1; tick("R3");
    rd_expect(8'h82, "R2 power-on then low voltage");
    pin = 1; tick("R3"); wdog = 1; tick("R3"); bop = 1; tick("R3"); lowv = 1; tick("R3");
    rd_expect(8'h72, "R3 accumulation");
    pin = 1; tick("R3"); wdog = 1; tick("R3"); pwr = 1; tick("R2");
    rd_expect(8'h80, "R2 power-on wipes");
    pwr = 1; pin = 1; tick("R2");
    rd_expect(8'hC0, "R2 power-on with pin");
    pin = 1; tick("R3");
    wdog = 1; rd_expect(8'h40, "R4 read before clear");
    rd_expect(8'h20, "R6 event beats clear");
    badr = 1; fetch = 0; tick("R7");
    rd_expect(8'h00, "R7 data access ignored");
    pin = 1; tick("R3");
    rd = 1; addr = 16'hFE00; #1; chk(rdata, 8'h00, "R9 other address"); tick("R9");
    rd_expect(8'h40, "R9 no clear from other address");
    repeat (4) tick("R5 idle");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule